// File: doc/BRIEF.md
# Inverting Latched Bus Transceiver

This block connects two parallel buses, called side A and side B, through two independent banks of storage cells, one bank for each direction of flow. Each direction has three active-low controls: a direction enable, a capture control and a drive control. While the direction enable and the capture control are both low, the bank follows its source bus. When the capture control rises, the bank freezes. While the direction enable is high, the bank holds whatever the capture control does. The far side drives the bitwise complement of the bank, but only while both the direction enable and the drive control are low.

The pads are not modelled as inout. Each side has an input vector, an output value vector and a single drive flag. The flag is high only when the pad would actively drive, and a pad wrapper turns it into a tri-state buffer. A parameter selects the storage form. It can be a true level-sensitive latch, or a flop that samples the source on the system clock while the bank is open. Both forms show the same values at clock boundaries as long as the source bus is stable around the edge. Reset is asserted asynchronously and released through a synchronizer.

Top module: `xcvr_inv_latched`

## Requirements
- R1: While `rst_n` is low, both drive flags are low and both banks are cleared. After reset and before any capture, each output vector reads all ones, which is the complement of the cleared bank.
- R2: With the direction enable low and the capture control low, the bank takes the source bus. At the next clock boundary the far output equals the bitwise complement of the source.
- R3: A rise of the capture control while the direction enable is low freezes the bank. Later changes of the source bus leave the far output unchanged.
- R4: While the direction enable is high, the source bus has no effect on the bank, even with the capture control low.
- R5: While a direction's drive control is high, the drive flag of its far side is low.
- R6: While a direction's enable is high, the drive flag of its far side is low.
- R7: The drive flag is high exactly when reset has been released and the direction's enable and drive control are both low. The output vector always carries the complement of the bank, bit for bit in the same positions.
- R8: The A-to-B direction (`ab_*`, source `a_in`, result on `b_out`/`b_drive`) and the B-to-A direction (`ba_*`, source `b_in`, result on `a_out`/`a_drive`) are independent. Controls or data of one direction never change the other direction's output.
- R9: The level-latch form (`MODE` = STORE_LEVEL) and the clock-sampled form (`MODE` = STORE_SAMPLED) give identical outputs and flags at every clock boundary when inputs change only between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock: reset release, and capture in the sampled form |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | WIDTH | Values seen at the A pads |
| a_out | output | WIDTH | Complement of the B-to-A bank, toward the A pads |
| a_drive | output | 1 | High when the A pads drive |
| b_in | input | WIDTH | Values seen at the B pads |
| b_out | output | WIDTH | Complement of the A-to-B bank, toward the B pads |
| b_drive | output | 1 | High when the B pads drive |
| ab_ce_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B capture control, low = open |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ba_ce_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A capture control, low = open |
| ba_oe_n | input | 1 | B-to-A drive control, active low |

## Verification
The bench builds two copies with the default WIDTH of 8 and SYNC_STAGES of 2. One copy uses STORE_LEVEL and the other STORE_SAMPLED, and every check compares both copies with a bench model and with each other. This makes any mismatch between the latch form and the sampled form visible. A width of 8 lets random data cover all bit positions quickly and keeps the complement easy to read. The synchronizer depth of two makes the wait between reset release and the first capture short enough for the directed reset-state check.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    STORE_LEVEL   = 1'b0,
    STORE_SAMPLED = 1'b1
  } store_mode_e;

  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int          WIDTH = 8,
  parameter store_mode_e MODE  = STORE_LEVEL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             le_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  logic open_en;
  assign open_en = ~ce_n & ~le_n;

  generate
    if (MODE == STORE_SAMPLED) begin : g_sampled
      logic [WIDTH-1:0] q_r;
      logic [WIDTH-1:0] q_nxt;
      always_comb q_nxt = open_en ? din : q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
      assign q = q_r;
    end else begin : g_level
      logic [WIDTH-1:0] q_l;
      always_latch begin
        if (!rst_n)       q_l <= '0;
        else if (open_en) q_l <= din;
      end
      assign q = q_l;
    end
  endgenerate
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] bank,
  output logic [WIDTH-1:0] pad_val,
  output logic             pad_en
);
  always_comb begin
    pad_val = ~bank;
    pad_en  = rst_n & ~ce_n & ~oe_n;
  end
endmodule

// File: rtl/xcvr_inv_latched.sv
module xcvr_inv_latched
  import xcvr_pkg::*;
#(
  parameter int          WIDTH       = 8,
  parameter store_mode_e MODE        = STORE_LEVEL,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             ab_ce_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n
);
  logic rst_sync_n;

  logic [NUM_DIRS-1:0][WIDTH-1:0] src_bus;
  logic [NUM_DIRS-1:0][WIDTH-1:0] bank_q;
  logic [NUM_DIRS-1:0][WIDTH-1:0] far_val;
  logic [NUM_DIRS-1:0]            far_en;
  logic [NUM_DIRS-1:0]            dir_ce_n;
  logic [NUM_DIRS-1:0]            dir_le_n;
  logic [NUM_DIRS-1:0]            dir_oe_n;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign src_bus[DIR_AB]  = a_in;
  assign src_bus[DIR_BA]  = b_in;
  assign dir_ce_n[DIR_AB] = ab_ce_n;
  assign dir_ce_n[DIR_BA] = ba_ce_n;
  assign dir_le_n[DIR_AB] = ab_le_n;
  assign dir_le_n[DIR_BA] = ba_le_n;
  assign dir_oe_n[DIR_AB] = ab_oe_n;
  assign dir_oe_n[DIR_BA] = ba_oe_n;

  generate
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      xcvr_store #(.WIDTH(WIDTH), .MODE(MODE)) u_store (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .ce_n  (dir_ce_n[d]),
        .le_n  (dir_le_n[d]),
        .din   (src_bus[d]),
        .q     (bank_q[d])
      );
      xcvr_drive #(.WIDTH(WIDTH)) u_drive (
        .rst_n   (rst_sync_n),
        .ce_n    (dir_ce_n[d]),
        .oe_n    (dir_oe_n[d]),
        .bank    (bank_q[d]),
        .pad_val (far_val[d]),
        .pad_en  (far_en[d])
      );
    end
  endgenerate

  assign b_out   = far_val[DIR_AB];
  assign b_drive = far_en[DIR_AB];
  assign a_out   = far_val[DIR_BA];
  assign a_drive = far_en[DIR_BA];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk
  import xcvr_pkg::*;
#(
  parameter int          WIDTH       = 8,
  parameter store_mode_e MODE        = STORE_LEVEL,
  parameter int          SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             ab_ce_n,
  input logic             ab_le_n,
  input logic             ab_oe_n,
  input logic             ba_ce_n,
  input logic             ba_le_n,
  input logic             ba_oe_n
);
  localparam int LIVE_MAX = SYNC_STAGES + 1;
  localparam int LIVE_W   = $clog2(LIVE_MAX + 1);

  logic [LIVE_W-1:0] live_cnt;
  logic              live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            live_cnt <= '0;
    else if (live_cnt != LIVE_W'(LIVE_MAX)) live_cnt <= live_cnt + 1'b1;
  end
  assign live = (live_cnt == LIVE_W'(LIVE_MAX));

  // R1
  always_comb begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!a_drive && !b_drive);
    end
  end

  // R5
  ab_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> !b_drive);
  // R5
  ba_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> !a_drive);
  // R6
  ab_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_ce_n |-> !b_drive);
  // R6
  ba_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_ce_n |-> !a_drive);
  // R4
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ce_n && $past(ab_ce_n)) |-> $stable(b_out));
  // R4
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_ce_n && $past(ba_ce_n)) |-> $stable(a_out));

  generate
    if (MODE == STORE_SAMPLED) begin : g_smp
      // R2
      ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(!ab_ce_n && !ab_le_n)) |-> (b_out == ~$past(a_in)));
      // R2
      ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(!ba_ce_n && !ba_le_n)) |-> (a_out == ~$past(b_in)));
    end else begin : g_lvl
      // R2
      ab_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ab_ce_n && !ab_le_n) |-> (b_out == ~a_in));
      // R2
      ba_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ba_ce_n && !ba_le_n) |-> (a_out == ~b_in));
    end
  endgenerate
endmodule

bind xcvr_inv_latched xcvr_chk #(
  .WIDTH(WIDTH), .MODE(MODE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_xcvr_inv_latched.sv
module sim_xcvr_inv_latched;
  import xcvr_pkg::*;

  localparam int  W   = 8;
  localparam time CLK = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_drv0, b_drv0, a_drv1, b_drv1;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_ab, exp_ba;
  bit released;

  always #(CLK/2) clk = ~clk;

  xcvr_inv_latched #(.WIDTH(W), .MODE(STORE_LEVEL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out0), .a_drive(a_drv0),
    .b_in(b_in), .b_out(b_out0), .b_drive(b_drv0),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n));

  xcvr_inv_latched #(.WIDTH(W), .MODE(STORE_SAMPLED)) u1 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out1), .a_drive(a_drv1),
    .b_in(b_in), .b_out(b_out1), .b_drive(b_drv1),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n));

  function automatic logic exp_flag(input logic ce, input logic oe, input bit rel);
    return rel && !ce && !oe;
  endfunction

  function automatic string flag_tag(input logic ce, input logic oe);
    if (oe) return "R5";
    if (ce) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R7 b_out lvl"}, b_out0, ~exp_ab);
    chk({tag, " R7 a_out lvl"}, a_out0, ~exp_ba);
    chk({tag, " R9 b_out smp"}, b_out1, ~exp_ab);
    chk({tag, " R9 a_out smp"}, a_out1, ~exp_ba);
    chk({flag_tag(ab_ce_n, ab_oe_n), " b_drive lvl"}, W'(b_drv0), W'(exp_flag(ab_ce_n, ab_oe_n, released)));
    chk({flag_tag(ba_ce_n, ba_oe_n), " a_drive lvl"}, W'(a_drv0), W'(exp_flag(ba_ce_n, ba_oe_n, released)));
    chk("R9 b_drive forms", W'(b_drv1), W'(b_drv0));
    chk("R9 a_drive forms", W'(a_drv1), W'(a_drv0));
  endtask

  task automatic apply(input logic [5:0] ctl, input logic [W-1:0] ad, input logic [W-1:0] bd);
    {ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n} = ctl;
    #1;
    a_in = ad;
    b_in = bd;
    if (!ab_ce_n && !ab_le_n) exp_ab = ad;
    if (!ba_ce_n && !ba_le_n) exp_ba = bd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    released = 1'b0;
    rst_n = 1'b0;
    exp_ab = '0;
    exp_ba = '0;
    {ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n} = 6'b000_000;
    a_in = 8'h5A;
    b_in = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: flags low while reset held even with all controls low
    chk("R1 b_drive in reset", W'(b_drv0 | b_drv1), '0);
    chk("R1 a_drive in reset", W'(a_drv0 | a_drv1), '0);
    apply(6'b010_010, 8'h5A, 8'hA5);
    rst_n = 1'b1;
    repeat (5) step();
    released = 1'b1;
    // R1: cleared banks read back inverted as all ones
    chk("R1 b_out after reset", b_out0 & b_out1, 8'hFF);
    chk("R1 a_out after reset", a_out0 & a_out1, 8'hFF);
    check_all("R1");

    // R2: transparent A-to-B
    apply(6'b000_110, 8'h3C, 8'h11);
    step();
    check_all("R2");
    chk("R2 b_out", b_out0, 8'hC3);

    // R3: freeze on capture rise, then change source
    apply(6'b010_110, 8'h3C, 8'h11);
    step();
    apply(6'b010_110, 8'h55, 8'h11);
    step();
    check_all("R3");
    chk("R3 b_out frozen", b_out1, 8'hC3);

    // R4: enable high, capture low, source changes
    apply(6'b100_110, 8'hAA, 8'h11);
    step();
    apply(6'b010_110, 8'hAA, 8'h11);
    step();
    check_all("R4");
    chk("R4 b_out held", b_out0, 8'hC3);

    // R8: B-to-A open while A-to-B held
    apply(6'b010_000, 8'hFF, 8'h0F);
    step();
    check_all("R8");
    chk("R8 a_out", a_out0, 8'hF0);
    chk("R8 b_out untouched", b_out1, 8'hC3);

    // R9: random traffic through both forms
    for (int i = 0; i < 600; i++) begin
      logic [5:0] ctl;
      ctl = 6'($urandom);
      apply(ctl, W'($urandom), W'($urandom));
      step();
      check_all("R9");
    end

    summary();
    $finish;
  end
endmodule